// File: doc/BRIEF.md
# Ramp Link Pattern Generator and Checker

This block tests the timing of a parallel data link. The transmit half drives a counting pattern onto the link, one step per transmit clock. The receive half captures the link on its own clock. The two clocks share a frequency, and the receive clock is the one whose phase gets shifted. The receive half predicts each arriving word from the one before it and counts every word that does not fit the count.

Scan software moves the receive clock phase in small steps. At each step it clears the counter, lets the link run for a while, and reads the count. The widest run of phase settings with a zero count marks the centre of the data eye. A lock flag shows that the pattern has been followed without a break for a set number of words.

The checker takes its starting point from the link itself, so it never needs to know the transmitter's current value. After a bad word it takes the next word as a fresh start. A single corrupted word therefore adds exactly one to the count.

Top module: `ramp_link_monitor`

## Requirements
- R1: While `txRstN` is low, `txRamp` is zero. After release, `txRamp` grows by one on every rising `txClk` edge and wraps from all ones to zero.
- R2: Each rising `rxClk` edge captures `rxData` together with `chkEnable`. A captured word is checked on the following edge. An unbroken ramp, including the wrap from all ones to zero, adds nothing to `errCount`.
- R3: The first captured word after `chkEnable` rises, after a clear, or after a mismatch is only a starting point. It never adds to `errCount`.
- R4: A checked word that is not one more (modulo 2^DATA_W) than the word before it adds exactly one to `errCount`. The count changes on the second rising `rxClk` edge after the word appears on `rxData`. The word after a bad word becomes the new starting point, so a lone bad word counts once.
- R5: `errCount` stops at 2^ERR_W-1 and does not wrap.
- R6: `chkClear`, sampled on a rising `rxClk` edge, sets `errCount` to zero, lowers `locked`, and makes the next enabled word a starting point. It wins over a mismatch checked on the same edge.
- R7: `locked` rises on the edge that checks the LOCK_LEN-th matching word in a row. It falls on a mismatch, on a clear, or when the captured enable is low.
- R8: While the captured enable is low, words are not checked and `errCount` keeps its value.
- R9: While `rxRstN` is low, `errCount` is zero and `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmit clock |
| txRstN | input | 1 | Asynchronous active-low reset, transmit side |
| txRamp | output | DATA_W | Ramp word driven onto the link |
| rxClk | input | 1 | Receive sampling clock, adjustable phase |
| rxRstN | input | 1 | Asynchronous active-low reset, receive side |
| chkEnable | input | 1 | Enables checking of captured words |
| chkClear | input | 1 | Synchronous clear of count, lock and starting point |
| rxData | input | DATA_W | Link word as seen at the receiver |
| errCount | output | ERR_W | Saturating pattern error count |
| locked | output | 1 | LOCK_LEN consecutive matching words seen |

## Verification
A wrong predicted word shows up on `errCount` two receive edges after a clean word arrives. The same fault blocks `locked`, so a lock that stays low after LOCK_LEN+2 clean cycles exposes it. A checker that fails to restart after a mismatch shows as a second count for one injected bad word, one edge after the first. A broken run counter moves the rising edge of `locked` away from the exact edge R7 predicts, and the tests watch that edge directly.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  // Strobes passed from the checker control to the checker datapath
  typedef struct packed {
    logic clr;    // clear count, run length and prediction state
    logic flush;  // checking suspended: drop run length
    logic seed;   // take the captured word as a new starting point
    logic hit;    // captured word matched the prediction
    logic miss;   // captured word broke the ramp
  } chkStrobe_t;
endpackage

// File: rtl/ramp_tx_gen.sv
module ramp_tx_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] ramp
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ramp <= '0;
    else       ramp <= ramp + DATA_W'(1);
  end
endmodule

// File: rtl/ramp_chk_dpath.sv
module ramp_chk_dpath
  import ramp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 16,
  parameter int LOCK_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  logic              chkEnable,
  input  chkStrobe_t        strobe,
  output logic              enQ,
  output logic              match,
  output logic              runNear,
  output logic              runFull,
  output logic [ERR_W-1:0]  errCount
);
  localparam int RUN_W = $clog2(LOCK_LEN + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_LEN);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(LOCK_LEN - 1);

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] expected;
  logic [RUN_W-1:0]  goodRun;

  // Input capture on the sampling clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      enQ   <= 1'b0;
    end else begin
      dataQ <= rxData;
      enQ   <= chkEnable;
    end
  end

  // Prediction of the next ramp word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         expected <= '0;
    else if (strobe.seed || strobe.hit) expected <= dataQ + DATA_W'(1);
  end

  assign match = (dataQ == expected);

  // Saturating error counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  errCount <= '0;
    else if (strobe.clr)                        errCount <= '0;
    else if (strobe.miss && errCount != ERR_MAX) errCount <= errCount + ERR_W'(1);
  end

  // Consecutive match run length, saturating at LOCK_LEN
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       goodRun <= '0;
    else if (strobe.clr || strobe.flush || strobe.miss) goodRun <= '0;
    else if (strobe.hit && goodRun != RUN_TOP)       goodRun <= goodRun + RUN_W'(1);
  end

  assign runNear = (goodRun >= RUN_PRE);
  assign runFull = (goodRun == RUN_TOP);

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> errCount == '0);
  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == ERR_MAX && !strobe.clr) |=> errCount == ERR_MAX);
  assert_seed_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.seed && !strobe.clr) |=> $stable(errCount));
  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !strobe.clr) |=> $stable(errCount));
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clr |=> (errCount == $past(errCount) || errCount == $past(errCount) + ERR_W'(1)));
endmodule

// File: rtl/ramp_chk_ctrl.sv
module ramp_chk_ctrl
  import ramp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chkClear,
  input  logic       enQ,
  input  logic       match,
  input  logic       runNear,
  input  logic       runFull,
  output chkStrobe_t strobe,
  output logic       locked
);
  typedef enum logic {WAIT_SEED, TRACK} chkState_t;
  chkState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (chkClear) begin
      strobe.clr = 1'b1;
      stateNext  = WAIT_SEED;
    end else if (!enQ) begin
      strobe.flush = 1'b1;
      stateNext    = WAIT_SEED;
    end else if (state == WAIT_SEED) begin
      strobe.seed = 1'b1;
      stateNext   = TRACK;
    end else if (match) begin
      strobe.hit = 1'b1;
    end else begin
      strobe.miss = 1'b1;
      stateNext   = WAIT_SEED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WAIT_SEED;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          locked <= 1'b0;
    else if (strobe.clr || strobe.flush || strobe.miss) locked <= 1'b0;
    else if (strobe.hit && runNear)                     locked <= 1'b1;
  end

  assert_lock_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> runFull);
  assert_miss_unlock_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.miss |=> !locked);
  assert_idle_unlock_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !chkClear) |=> !locked);
endmodule

// File: rtl/ramp_link_monitor.sv
module ramp_link_monitor
  import ramp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 16,
  parameter int LOCK_LEN = 16
) (
  input  logic              txClk,
  input  logic              txRstN,
  output logic [DATA_W-1:0] txRamp,
  input  logic              rxClk,
  input  logic              rxRstN,
  input  logic              chkEnable,
  input  logic              chkClear,
  input  logic [DATA_W-1:0] rxData,
  output logic [ERR_W-1:0]  errCount,
  output logic              locked
);
  chkStrobe_t strobe;
  logic enQ, match, runNear, runFull;

  ramp_tx_gen #(.DATA_W(DATA_W)) uTx (
    .clk(txClk), .rstN(txRstN), .ramp(txRamp)
  );

  ramp_chk_dpath #(.DATA_W(DATA_W), .ERR_W(ERR_W), .LOCK_LEN(LOCK_LEN)) uDpath (
    .clk(rxClk), .rstN(rxRstN), .rxData(rxData), .chkEnable(chkEnable),
    .strobe(strobe), .enQ(enQ), .match(match), .runNear(runNear),
    .runFull(runFull), .errCount(errCount)
  );

  ramp_chk_ctrl uCtrl (
    .clk(rxClk), .rstN(rxRstN), .chkClear(chkClear), .enQ(enQ),
    .match(match), .runNear(runNear), .runFull(runFull),
    .strobe(strobe), .locked(locked)
  );
endmodule

// File: tb/sim_ramp_link_monitor.sv
module sim_ramp_link_monitor;
  localparam int DW = 8;
  localparam int EW = 4;
  localparam int LL = 4;

  logic txClk = 1'b0, rxClk = 1'b0;
  logic txRstN = 1'b0, rxRstN = 1'b0;
  logic chkEnable = 1'b0, chkClear = 1'b0;
  logic [DW-1:0] txRamp, rxData;
  logic [EW-1:0] errCount;
  logic locked;
  logic [1:0] injMode = 2'd0;
  logic [DW-1:0] injConst = 8'hA5;
  int checks = 0, errors = 0;

  assign rxData = (injMode == 2'd1) ? txRamp + 8'h40 :
                  (injMode == 2'd2) ? injConst : txRamp;

  ramp_link_monitor #(.DATA_W(DW), .ERR_W(EW), .LOCK_LEN(LL)) u0 (
    .txClk(txClk), .txRstN(txRstN), .txRamp(txRamp),
    .rxClk(rxClk), .rxRstN(rxRstN), .chkEnable(chkEnable), .chkClear(chkClear),
    .rxData(rxData), .errCount(errCount), .locked(locked)
  );

  always #5 txClk = ~txClk;
  initial begin
    #3;
    forever begin rxClk = 1'b1; #5; rxClk = 1'b0; #5; end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rxWait(int n);
    for (int i = 0; i < n; i++) @(negedge rxClk);
  endtask

  task automatic testReset();
    rxWait(3);
    check("R1", txRamp, 0, "ramp in reset");
    check("R9", errCount, 0, "count in reset");
    check("R9", locked, 0, "lock in reset");
    txRstN = 1'b1; rxRstN = 1'b1;
  endtask

  task automatic testTxRamp();
    int bad = 0;
    logic [DW-1:0] prev;
    @(negedge txClk);
    prev = txRamp;
    for (int i = 0; i < 300; i++) begin
      @(negedge txClk);
      if (txRamp != prev + 8'd1) bad++;
      prev = txRamp;
    end
    check("R1", bad, 0, "ramp steps incl wrap");
  endtask

  task automatic testCleanLock();
    @(negedge rxClk); chkEnable = 1'b1; chkClear = 1'b1;
    @(negedge rxClk); chkClear = 1'b0;
    rxWait(LL);
    check("R7", locked, 0, "lock one edge early");
    rxWait(1);
    check("R7", locked, 1, "lock on LOCK_LEN-th match");
    rxWait(300);
    check("R2", errCount, 0, "clean ramp through wrap");
    check("R2", locked, 1, "lock held on clean ramp");
  endtask

  task automatic testSingleError();
    int base = errCount;
    @(negedge rxClk); injMode = 2'd1;
    @(negedge rxClk); injMode = 2'd0;
    check("R4", errCount, base, "count before compare edge");
    rxWait(1);
    check("R4", errCount, base + 1, "count on compare edge");
    check("R7", locked, 0, "lock dropped on mismatch");
    rxWait(12);
    check("R4", errCount, base + 1, "lone bad word counted once");
    check("R3", locked, 1, "relock after reseed");
  endtask

  task automatic testTwoErrors();
    int base = errCount;
    for (int k = 0; k < 2; k++) begin
      @(negedge rxClk); injMode = 2'd1;
      @(negedge rxClk); injMode = 2'd0;
      rxWait(10);
    end
    check("R4", errCount, base + 2, "two separate bad words");
  endtask

  task automatic testSaturation();
    @(negedge rxClk); injMode = 2'd2;
    rxWait(40);
    check("R5", errCount, 15, "saturated under garbage");
    injMode = 2'd0;
    rxWait(10);
    check("R5", errCount, 15, "still saturated, no wrap");
    chkClear = 1'b1;
    @(negedge rxClk); chkClear = 1'b0;
    check("R6", errCount, 0, "clear zeroes count");
    check("R6", locked, 0, "clear drops lock");
    rxWait(LL + 4);
    check("R6", errCount, 0, "no count after clear reseed");
  endtask

  task automatic testClearPriority();
    @(negedge rxClk); injMode = 2'd1;
    @(negedge rxClk); injMode = 2'd0; chkClear = 1'b1;
    @(negedge rxClk); chkClear = 1'b0;
    check("R6", errCount, 0, "clear beats same-edge mismatch");
    rxWait(10);
    check("R6", errCount, 0, "count stays zero after clear");
    check("R7", locked, 1, "relock after clear");
  endtask

  task automatic testDisabled();
    int base = errCount;
    @(negedge rxClk); chkEnable = 1'b0; injMode = 2'd2;
    rxWait(20);
    check("R8", errCount, base, "no counting while disabled");
    check("R7", locked, 0, "lock low while disabled");
    chkEnable = 1'b1; injMode = 2'd0;
    rxWait(LL + 4);
    check("R3", errCount, base, "first word after enable seeds");
    check("R3", locked, 1, "lock after re-enable");
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testTxRamp();
    testCleanLock();
    testSingleError();
    testTwoErrors();
    testSaturation();
    testClearPriority();
    testDisabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule